// File: doc/BRIEF.md
# Interruptible Repeated Byte-Copy Sequencer

This block executes one block-copy command as a chain of single-byte moves over a simple synchronous memory port. A command supplies a byte count, a source address, a destination address and a direction. For each byte the engine reads the source location, writes that byte to the destination, decrements the count and steps both addresses by one, either up or down.

An interrupt request can end the copy at any byte boundary. The only progress state is the three live registers: the remaining count and the two addresses. When the engine stops early, those registers hold exactly where the copy must resume, and a flag says that the command has to be issued again. A later start that is loaded from the exposed count and addresses finishes the remaining bytes. The final memory contents are the same as those of a run that was never interrupted.

Top module: `rep_copy_engine`

## Requirements
- R1: A command of N bytes performs N single-byte moves in order: each move reads the current source address and then writes the byte it read to the current destination address.
- R2: The remaining count (`curCount`) drops by exactly one for every byte written.
- R3: After each move both addresses change by one in the same direction: increment when `dirDown` was 0 at start, decrement when it was 1.
- R4: Each move takes two cycles. A read strobe cycle is always followed directly by a write strobe cycle, so a byte whose read has begun is always written before the engine stops.
- R5: `irqReq` is sampled only in the write cycle of a move. If the engine stops there, `curCount` equals the start count minus the bytes already written, and `curSrc`/`curDst` address the next byte.
- R6: A stop caused by an interrupt while bytes remain raises `intrPulse` for one cycle and sets `restartFlag`. `restartFlag` then stays high until the next start.
- R7: A start with a count of 0 raises `donePulse` in the next cycle and makes no memory access.
- R8: `donePulse` and `intrPulse` are never high together. If an interrupt coincides with the last byte, the command completes with `donePulse`, and `restartFlag` stays low.
- R9: Restarting with the exposed `curCount`, `curSrc` and `curDst` yields the same final memory image as an uninterrupted copy.
- R10: Every start with a nonzero count moves at least one byte before an interrupt can stop it. A start received while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command; sampled only when idle |
| dirDown | input | 1 | 0: addresses increment, 1: addresses decrement |
| startCount | input | CW | Bytes to copy |
| startSrc | input | AW | First source address |
| startDst | input | AW | First destination address |
| irqReq | input | 1 | Interrupt request, level sensitive |
| memRdEn | output | 1 | Read strobe; data is returned in the next cycle |
| memWrEn | output | 1 | Write strobe |
| memAddr | output | AW | Memory address for the read or the write |
| memWrData | output | DW | Write data |
| memRdData | input | DW | Registered read data |
| busy | output | 1 | A command is in progress |
| donePulse | output | 1 | One-cycle pulse when a command completes |
| intrPulse | output | 1 | One-cycle pulse when a command stops early |
| restartFlag | output | 1 | The stopped command must be issued again |
| curCount | output | CW | Live remaining count |
| curSrc | output | AW | Live source address |
| curDst | output | AW | Live destination address |

## Verification
Two events can fall in the same cycle: the write of the final byte and a pending interrupt. The bench holds `irqReq` high for the whole of a three-byte downward copy. This forces a stop after every byte and a restart from the exposed registers each time. In the last run the interrupt meets the final byte, and the bench requires `donePulse` without `intrPulse` and with `restartFlag` low. A scoreboard compares every write against the byte sequence of one uninterrupted copy, and the memory image is compared at the end.

// File: rtl/rcopy_pkg.sv
package rcopy_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} cstate_t;

  typedef struct packed {
    logic load;    // take start values into the progress registers
    logic step;    // one byte moved: count down, pointers advance
    logic useDst;  // drive destination address on the memory port
  } dpCtl_t;
endpackage

// File: rtl/rcopy_dp.sv
module rcopy_dp
  import rcopy_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dpCtl_t        ctl,
  input  logic [CW-1:0] startCount,
  input  logic [AW-1:0] startSrc,
  input  logic [AW-1:0] startDst,
  input  logic          dirDown,
  input  logic [DW-1:0] memRdData,
  output logic [CW-1:0] count,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic          startZero,
  output logic          countLast
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ADR_ONE = AW'(1);

  logic goDown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      src    <= '0;
      dst    <= '0;
      goDown <= 1'b0;
    end else if (ctl.load) begin
      count  <= startCount;
      src    <= startSrc;
      dst    <= startDst;
      goDown <= dirDown;
    end else if (ctl.step) begin
      count <= count - CNT_ONE;
      src   <= goDown ? src - ADR_ONE : src + ADR_ONE;
      dst   <= goDown ? dst - ADR_ONE : dst + ADR_ONE;
    end
  end

  assign memAddr   = ctl.useDst ? dst : src;
  assign memWrData = memRdData;
  assign startZero = (startCount == '0);
  assign countLast = (count == CNT_ONE);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> (count == $past(count) - CNT_ONE));

  // R3
  ptr_same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> ((src - $past(src)) == (dst - $past(dst))) &&
                 (((src - $past(src)) == ADR_ONE) || ((src - $past(src)) == '1)));
endmodule

// File: rtl/rcopy_ctrl.sv
module rcopy_ctrl
  import rcopy_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   startZero,
  input  logic   countLast,
  input  logic   irqReq,
  output dpCtl_t ctl,
  output logic   memRdEn,
  output logic   memWrEn,
  output logic   busy,
  output logic   donePulse,
  output logic   intrPulse,
  output logic   restartFlag
);
  cstate_t state, nextState;
  logic doneNext, intrNext;

  always_comb begin
    nextState = state;
    ctl       = '0;
    memRdEn   = 1'b0;
    memWrEn   = 1'b0;
    doneNext  = 1'b0;
    intrNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          if (startZero) doneNext = 1'b1;
          else           nextState = ST_READ;
        end
      end
      ST_READ: begin
        memRdEn   = 1'b1;
        nextState = ST_WRITE;
      end
      ST_WRITE: begin
        memWrEn    = 1'b1;
        ctl.useDst = 1'b1;
        ctl.step   = 1'b1;
        if (countLast) begin
          doneNext  = 1'b1;
          nextState = ST_IDLE;
        end else if (irqReq) begin
          intrNext  = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_READ;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      donePulse   <= 1'b0;
      intrPulse   <= 1'b0;
      restartFlag <= 1'b0;
    end else begin
      state     <= nextState;
      donePulse <= doneNext;
      intrPulse <= intrNext;
      if (intrNext)      restartFlag <= 1'b1;
      else if (ctl.load) restartFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

  // R8
  done_intr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(donePulse && intrPulse));

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |=> memWrEn);

  // R7
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && startZero) |=> (donePulse && !memRdEn && !memWrEn));

  // R10
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !startZero) |=> memRdEn);

  // R6
  intr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intrPulse |-> restartFlag);
endmodule

// File: rtl/rep_copy_engine.sv
module rep_copy_engine
  import rcopy_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dirDown,
  input  logic [CW-1:0] startCount,
  input  logic [AW-1:0] startSrc,
  input  logic [AW-1:0] startDst,
  input  logic          irqReq,
  output logic          memRdEn,
  output logic          memWrEn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  input  logic [DW-1:0] memRdData,
  output logic          busy,
  output logic          donePulse,
  output logic          intrPulse,
  output logic          restartFlag,
  output logic [CW-1:0] curCount,
  output logic [AW-1:0] curSrc,
  output logic [AW-1:0] curDst
);
  dpCtl_t ctl;
  logic   startZero, countLast;

  rcopy_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .startZero(startZero),
    .countLast(countLast), .irqReq(irqReq), .ctl(ctl),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .busy(busy),
    .donePulse(donePulse), .intrPulse(intrPulse), .restartFlag(restartFlag)
  );

  rcopy_dp #(.AW(AW), .CW(CW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .startCount(startCount),
    .startSrc(startSrc), .startDst(startDst), .dirDown(dirDown),
    .memRdData(memRdData), .count(curCount), .src(curSrc), .dst(curDst),
    .memAddr(memAddr), .memWrData(memWrData), .startZero(startZero),
    .countLast(countLast)
  );
endmodule

// File: tb/rep_copy_engine_bench.sv
module rep_copy_engine_bench;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int MEMSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dirDown = 1'b0, irqReq = 1'b0;
  logic [CW-1:0] startCount = '0;
  logic [AW-1:0] startSrc = '0, startDst = '0;
  logic memRdEn, memWrEn, busy, donePulse, intrPulse, restartFlag;
  logic [AW-1:0] memAddr, curSrc, curDst;
  logic [DW-1:0] memWrData, memRdData;
  logic [CW-1:0] curCount;

  logic [DW-1:0] mem [MEMSZ];
  logic [DW-1:0] refMem [MEMSZ];
  logic [DW-1:0] rdReg = '0;

  int checks = 0, fails = 0;
  int rdTotal = 0, wrTotal = 0;
  int lastWrites;
  bit gotDone, gotIntr;
  logic [AW+DW-1:0] expQ [$];

  always #10 clk = ~clk;

  rep_copy_engine u_rep_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dirDown(dirDown),
    .startCount(startCount), .startSrc(startSrc), .startDst(startDst),
    .irqReq(irqReq), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .busy(busy),
    .donePulse(donePulse), .intrPulse(intrPulse), .restartFlag(restartFlag),
    .curCount(curCount), .curSrc(curSrc), .curDst(curDst)
  );

  always @(posedge clk) begin
    if (memWrEn) mem[memAddr] <= memWrData;
    if (memRdEn) rdReg <= mem[memAddr];
  end
  assign memRdData = rdReg;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes, counts accesses, watches pulse exclusion
  always @(negedge clk) begin
    if (rst_n) begin
      if (memRdEn) rdTotal++;
      if (memWrEn) begin
        wrTotal++;
        if (expQ.size() == 0) chk(1'b0, "R1", "unexpected write addr", int'(memAddr), 0);
        else begin
          logic [AW+DW-1:0] e;
          e = expQ.pop_front();
          chk({memAddr, memWrData} == e, "R1", "write addr/data",
              int'({memAddr, memWrData}), int'(e));
        end
      end
      if (donePulse && intrPulse) chk(1'b0, "R8", "done with intr", 1, 0);
    end
  end

  // driver: expected write sequence of one uninterrupted copy
  task automatic pushCopy(input int n, input int s, input int d, input bit down);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] sa, da;
      sa = AW'(down ? s - i : s + i);
      da = AW'(down ? d - i : d + i);
      refMem[da] = refMem[sa];
      expQ.push_back({da, refMem[da]});
    end
  endtask

  task automatic runCmd(input int n, input int s, input int d, input bit down,
                        input int irqAfter);
    int w;
    w = 0;
    gotDone = 0;
    gotIntr = 0;
    @(negedge clk);
    start = 1'b1; startCount = CW'(n); startSrc = AW'(s); startDst = AW'(d);
    dirDown = down;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 2000; t++) begin
      if (donePulse) begin gotDone = 1; break; end
      if (intrPulse) begin gotIntr = 1; break; end
      if (memWrEn) begin
        w++;
        if (w == irqAfter) irqReq = 1'b1;
      end
      @(negedge clk);
    end
    if (!gotDone && !gotIntr) chk(1'b0, "R1", "command never ended", 0, 1);
    lastWrites = w;
  endtask

  task automatic cmpMem(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== refMem[i]) bad++;
    chk(bad == 0, req, "memory image mismatches", bad, 0);
  endtask

  initial begin
    #(20ns * 200000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0, w0;
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i] = DW'(i * 7 + 3);
      refMem[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !memRdEn && !memWrEn, "R4", "reset strobes/busy", int'(busy), 0);
    chk(!donePulse && !intrPulse && !restartFlag, "R6", "reset flags",
        int'({donePulse, intrPulse, restartFlag}), 0);
    chk(curCount == 0, "R2", "reset count", int'(curCount), 0);

    // upward copy of 5
    pushCopy(5, 'h10, 'h80, 0);
    runCmd(5, 'h10, 'h80, 0, 0);
    chk(gotDone && !gotIntr, "R1", "up copy done", int'(gotDone), 1);
    chk(curCount == 0, "R2", "up copy count", int'(curCount), 0);
    chk(curSrc == 'h15 && curDst == 'h85, "R3", "up copy pointers",
        int'({curSrc, curDst}), 'h1585);
    chk(expQ.size() == 0, "R1", "up copy writes left", expQ.size(), 0);
    cmpMem("R1");

    // downward copy of 4
    pushCopy(4, 'h30, 'hA0, 1);
    runCmd(4, 'h30, 'hA0, 1, 0);
    chk(gotDone, "R1", "down copy done", int'(gotDone), 1);
    chk(curSrc == 'h2C && curDst == 'h9C, "R3", "down copy pointers",
        int'({curSrc, curDst}), 'h2C9C);
    cmpMem("R3");

    // zero count
    r0 = rdTotal; w0 = wrTotal;
    runCmd(0, 'h50, 'h60, 0, 0);
    chk(gotDone && !gotIntr, "R7", "zero count done", int'(gotDone), 1);
    chk(rdTotal == r0 && wrTotal == w0, "R7", "zero count accesses",
        (rdTotal - r0) + (wrTotal - w0), 0);

    // interrupt after 3 of 10, then restart
    pushCopy(10, 'h40, 'hC0, 0);
    runCmd(10, 'h40, 'hC0, 0, 3);
    irqReq = 1'b0;
    chk(gotIntr && !gotDone, "R6", "mid-copy stop pulse", int'(gotIntr), 1);
    chk(restartFlag, "R6", "restart flag set", int'(restartFlag), 1);
    chk(curCount == 7, "R5", "remaining count", int'(curCount), 7);
    chk(curSrc == 'h43 && curDst == 'hC3, "R5", "resume pointers",
        int'({curSrc, curDst}), 'h43C3);
    chk(lastWrites == 3, "R4", "bytes written before stop", lastWrites, 3);
    runCmd(int'(curCount), int'(curSrc), int'(curDst), 0, 0);
    chk(gotDone && !restartFlag, "R9", "restart completes", int'(restartFlag), 0);
    chk(curSrc == 'h4A && curDst == 'hCA, "R9", "final pointers",
        int'({curSrc, curDst}), 'h4ACA);
    chk(expQ.size() == 0, "R9", "writes left after restart", expQ.size(), 0);
    cmpMem("R9");

    // irq held high over a 3-byte downward copy
    pushCopy(3, 'h2F, 'h9F, 1);
    irqReq = 1'b1;
    runCmd(3, 'h2F, 'h9F, 1, 0);
    chk(gotIntr && lastWrites == 1, "R10", "first run moved one byte", lastWrites, 1);
    chk(curCount == 2 && curSrc == 'h2E, "R5", "after first stop",
        int'({curCount, curSrc}), 'h022E);
    runCmd(int'(curCount), int'(curSrc), int'(curDst), 1, 0);
    chk(gotIntr && lastWrites == 1 && curCount == 1, "R10", "second run progress",
        int'(curCount), 1);
    runCmd(int'(curCount), int'(curSrc), int'(curDst), 1, 0);
    chk(gotDone && !gotIntr, "R8", "last byte with irq completes", int'(gotDone), 1);
    chk(!restartFlag, "R8", "no restart flag on completion", int'(restartFlag), 0);
    irqReq = 1'b0;
    chk(expQ.size() == 0, "R9", "held-irq writes left", expQ.size(), 0);
    cmpMem("R9");

    // start while busy is ignored
    pushCopy(4, 'h01, 'hE0, 0);
    @(negedge clk);
    start = 1'b1; startCount = 4; startSrc = 'h01; startDst = 'hE0; dirDown = 0;
    @(negedge clk);
    startCount = 9; startSrc = 'h70; startDst = 'h20;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 100 && !donePulse; t++) @(negedge clk);
    chk(donePulse && curSrc == 'h05 && curDst == 'hE4, "R10", "busy start ignored",
        int'({curSrc, curDst}), 'h05E4);
    cmpMem("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule